// File: doc/BRIEF.md
# Signed Array Multiplier (Two's Complement, Sign-Corrected)

This block multiplies two signed two's complement operands of `W` bits each and returns their full `2W`-bit signed product, with no clock and no state. The default width is 4, giving an 8-bit product that covers every result from -56 up to +64.

Each single-bit product is one AND gate. A partial product that pairs exactly one sign bit with a non-sign bit is inverted. The term that pairs the two sign bits is not. Two constant bits then restore the value: a 1 at weight `2^W`, and a 1 at weight `2^(2W-1)`. The second is the same as subtracting `2^(2W-1)` modulo `2^(2W)`. With this correction no subtractor is needed anywhere in the array.

The resulting rows are reduced by a chain of carry-save stages built from full-adder cells. A ripple adder made of the same cells resolves the final pair. The block suits a datapath that needs a small signed product within one cycle.

Top module: `bw_signed_mult`

## Requirements
- R1: For every pair of operands, `product` equals the two's complement product of `op_x` and `op_y`, both read as signed `W`-bit values, written as `2W` bits.
- R2: The block is purely combinational. `product` follows a change of the operands within the same clock cycle, without any clock edge.
- R3: The most negative value squared gives the largest positive result. For `W`=4, (-8)×(-8) = +64, which is `product` = 8'h40 with bit 7 clear.
- R4: If either operand is zero, `product` is all zeros.
- R5: Multiplying by +1 returns the other operand sign-extended to `2W` bits. For example, 1×(-3) = 8'hFD.
- R6: Multiplying by -1 (all ones) negates the other operand without overflow. For example, (-8)×(-1) = 8'h08.
- R7: A nonzero product has its top bit (bit `2W-1`) equal to the XOR of the two operand sign bits (bit `W-1` of each).
- R8: Mixed-sign operands that set every sign-cross partial product give the correct negative result. For example, 7×(-8) = -56 = 8'hC8 and (-8)×7 = 8'hC8.
- R9: Every carry-save stage keeps the sum of its inputs modulo `2^(2W)`. The final adder's `2W`-bit sum equals the sum of its two inputs modulo `2^(2W)`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | W | Signed multiplicand, two's complement |
| op_y | input | W | Signed multiplier, two's complement |
| product | output | 2W | Signed product, two's complement |

## Verification
All 256 operand pairs are applied, one per cycle, and compared with a product the bench computes from integers. This covers every mix of sign bits, so each inverted cross term and both correction bits are exercised.

A separate group of patterns is reported under its own tags, because each one points at a different kind of fault:
- Zero operands catch a stray correction constant.
- Operands of +1 and -1 catch an inverted sign row.
- The most negative value squared shows whether the top bit is inverted rather than dropped.
- Maximum positive times most negative shows whether the sign-cross terms are inverted at the right weights.

// File: rtl/bw_pkg.sv
package bw_pkg;

  // Sign-cross terms (exactly one index at the sign position) enter inverted.
  function automatic logic pp_bit(input logic xi, input logic yj,
                                  input int i, input int j, input int w);
    logic inv;
    inv = (i == w - 1) ^ (j == w - 1);
    return (xi & yj) ^ inv;
  endfunction

  function automatic logic [2:0] add3(input logic a, input logic b, input logic c);
    return {1'b0, a & b | c & (a ^ b), a ^ b ^ c};
  endfunction

endpackage

// File: rtl/bw_full_add.sv
module bw_full_add (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic [2:0] r;
  assign r  = bw_pkg::add3(a, b, ci);
  assign s  = r[0];
  assign co = r[1];
endmodule

// File: rtl/bw_pp_row.sv
module bw_pp_row #(
  parameter int W   = 4,
  parameter int ROW = 0,
  localparam int W2 = 2 * W
) (
  input  logic [W-1:0]  x,
  input  logic          yj,
  output logic [W2-1:0] row
);
  always_comb begin
    row = '0;
    for (int i = 0; i < W; i++)
      row[ROW + i] = bw_pkg::pp_bit(x[i], yj, i, ROW, W);
  end
endmodule

// File: rtl/bw_csa_row.sv
module bw_csa_row #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] c,
  output logic [N-1:0] s,
  output logic [N-1:0] cs
);
  logic [N-1:0] co;

  assign cs[0] = 1'b0;

  for (genvar k = 0; k < N - 1; k++) begin : g_cell
    bw_full_add u_fa (.a(a[k]), .b(b[k]), .ci(c[k]), .s(s[k]), .co(co[k]));
    assign cs[k + 1] = co[k];
  end

  // Carry out of the top column falls outside the product width.
  assign s[N-1]  = a[N-1] ^ b[N-1] ^ c[N-1];
  assign co[N-1] = 1'b0;

  always_comb begin
    a_r9_csa_keeps_sum: assert (N'(s + cs) == N'(a + b + c))
      else $error("R9: carry-save stage lost value");
  end
endmodule

// File: rtl/bw_ripple.sv
module bw_ripple #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum
);
  logic [N-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar k = 0; k < N - 1; k++) begin : g_bit
    bw_full_add u_fa (.a(a[k]), .b(b[k]), .ci(cy[k]), .s(sum[k]), .co(cy[k + 1]));
  end

  assign sum[N-1] = a[N-1] ^ b[N-1] ^ cy[N-1];

  always_comb begin
    a_r9_ripple_sum: assert (sum == N'(a + b))
      else $error("R9: final adder mismatch");
  end
endmodule

// File: rtl/bw_signed_mult.sv
module bw_signed_mult #(
  parameter int W = 4,
  localparam int W2 = 2 * W
) (
  input  logic [W-1:0]  op_x,
  input  logic [W-1:0]  op_y,
  output logic [W2-1:0] product
);
  // Correction: +2^W, and -2^(2W-1) expressed as +2^(2W-1) modulo 2^(2W).
  localparam logic [W2-1:0] CORR = (W2'(1) << W) | (W2'(1) << (W2 - 1));

  logic [W2-1:0] rows  [0:W];
  logic [W2-1:0] acc_s [0:W-1];
  logic [W2-1:0] acc_c [0:W-1];

  for (genvar j = 0; j < W; j++) begin : g_row
    bw_pp_row #(.W(W), .ROW(j)) u_row (.x(op_x), .yj(op_y[j]), .row(rows[j]));
  end
  assign rows[W] = CORR;

  assign acc_s[0] = rows[0];
  assign acc_c[0] = rows[1];

  for (genvar k = 1; k < W; k++) begin : g_stage
    bw_csa_row #(.N(W2)) u_csa (
      .a(acc_s[k-1]), .b(acc_c[k-1]), .c(rows[k+1]),
      .s(acc_s[k]), .cs(acc_c[k])
    );
  end

  bw_ripple #(.N(W2)) u_final (.a(acc_s[W-1]), .b(acc_c[W-1]), .sum(product));

  // Assertion-only views of the operands and their reference product.
  logic [W2-1:0] x_ext, y_ext, ref_p;
  logic          is_nonzero;
  assign x_ext      = {{W{op_x[W-1]}}, op_x};
  assign y_ext      = {{W{op_y[W-1]}}, op_y};
  assign ref_p      = x_ext * y_ext;
  assign is_nonzero = (op_x != '0) && (op_y != '0);

  always_comb begin
    a_r1_matches_signed: assert (product == ref_p)
      else $error("R1: product differs from signed reference");
    a_r4_zero_operand: assert (is_nonzero || product == '0)
      else $error("R4: zero operand gave nonzero product");
    a_r7_sign_bit: assert (!is_nonzero || product[W2-1] == (op_x[W-1] ^ op_y[W-1]))
      else $error("R7: wrong product sign");
    a_r5_unit: assert (op_x != W'(1) || product == y_ext)
      else $error("R5: unit multiplier failed");
  end
endmodule

// File: tb/bw_signed_mult_test.sv
module bw_signed_mult_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_x = '0, op_y = '0;
  logic [7:0] product;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 0;
  int         exp_q[$];

  always #5 clk = ~clk;

  bw_signed_mult #(.W(4)) uut (.op_x(op_x), .op_y(op_y), .product(product));

  function automatic int sval(input logic [3:0] v);
    return (v >= 4'd8) ? int'(v) - 16 : int'(v);
  endfunction

  function automatic string tag_for(input int sx, input int sy);
    if (sx == -8 && sy == -8) return "R3";
    if (sx == 0 || sy == 0) return "R4";
    if (sx == 1 || sy == 1) return "R5";
    if (sx == -1 || sy == -1) return "R6";
    if ((sx == 7 && sy == -8) || (sx == -8 && sy == 7)) return "R8";
    if ((sx < 0) != (sy < 0)) return "R7";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: x=%0d y=%0d product=%02h expected=%02h",
               tag, sval(op_x), sval(op_y), act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, cycles=5000 expected<5000");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4", product, 8'h00);  // operands held at zero through reset
    rst = 1'b0;

    // R1/R2: every pair, one per cycle, compared in the same cycle.
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(posedge clk); #1;
        op_x = 4'(a);
        op_y = 4'(b);
        exp_q.push_back((sval(op_x) * sval(op_y)) & 255);
        @(negedge clk);
        check(tag_for(sval(op_x), sval(op_y)), product, 8'(exp_q.pop_front()));
      end
    end

    // Directed corners with literal expectations.
    @(posedge clk); #1; op_x = 4'h8; op_y = 4'h8;
    @(negedge clk); check("R3", product, 8'h40);
    check("R7", {7'b0, product[7]}, 8'h00);
    @(posedge clk); #1; op_x = 4'h7; op_y = 4'h8;
    @(negedge clk); check("R8", product, 8'hC8);
    @(posedge clk); #1; op_x = 4'h8; op_y = 4'h7;
    @(negedge clk); check("R8", product, 8'hC8);
    @(posedge clk); #1; op_x = 4'h8; op_y = 4'hF;
    @(negedge clk); check("R6", product, 8'h08);
    @(posedge clk); #1; op_x = 4'h1; op_y = 4'hD;
    @(negedge clk); check("R5", product, 8'hFD);
    @(posedge clk); #1; op_x = 4'h0; op_y = 4'h8;
    @(negedge clk); check("R4", product, 8'h00);
    @(posedge clk); #1; op_x = 4'h7; op_y = 4'h7;
    @(negedge clk); check("R9", product, 8'h31);

    // R2: mid-cycle change, observed before any clock edge.
    op_x = 4'h3; op_y = 4'hE;
    #1 check("R2", product, 8'hFA);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule